// File: doc/BRIEF.md
# Four-Bit Up/Down Wrap-Around Counter

This block is a four-bit counter that wraps through sixteen states. Two mode bits choose one of three actions each clock: step up, step down, or keep the present value. The storage is an up-only binary counter stage. That stage has a synchronous clear, a synchronous parallel load and a count enable.

Stepping down is not a native action of that stage. Combinational logic computes the predecessor of the present value. The stage then loads that value through its parallel input on every down-mode cycle.

The block drives the count and two terminal-count flags. The up flag marks the last state before an upward wrap. The down flag marks the last state before a downward wrap. A parent design can use either flag to chain a further stage or to mark the end of a period.

Top module: `updown_wrap16`

## Requirements
- R1: When `sclr` is 1 at a rising edge, `count` is 0 after that edge, whatever the mode bits are. Clear takes priority over both load and increment.
- R2: With `go_up`=1 and `go_dn`=0 (up mode), each rising edge raises `count` by one modulo 16, so 15 is followed by 0.
- R3: With `go_up`=0 and `go_dn`=1 (down mode), each rising edge lowers `count` by one modulo 16, so 0 is followed by 15 and 1 is followed by 0.
- R4: When `go_up` equals `go_dn` (both 0 or both 1), `count` does not change at a rising edge.
- R5: `tc_up` is 1 exactly when up mode is selected and `count` is 15, in the same cycle, with no clock delay.
- R6: `tc_dn` is 1 exactly when down mode is selected and `count` is 0, in the same cycle, with no clock delay.
- R7: Sixteen down-mode edges starting from 0 produce 15, 14, and so on down to 1, then 0. Every value is visited once, and the count ends back at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| sclr | input | 1 | Synchronous clear to zero |
| go_up | input | 1 | Mode bit for up counting |
| go_dn | input | 1 | Mode bit for down counting |
| count | output | 4 | Present state |
| tc_up | output | 1 | Up terminal count: state 15 in up mode |
| tc_dn | output | 1 | Down terminal count: state 0 in down mode |

## Verification
The bound checker covers the following on every cycle:
- the effect of a clear;
- the one-step move in each direction, including both wraps;
- holding under either equal mode pair;
- that each terminal flag is followed by the matching wrap;
- that the two flags never rise together.

Only the bench's scenarios can show the rest:
- that every state of a full down pass is visited in strict descending order;
- that each flag is low for every state other than its own;
- that clear wins while a count is in progress.

// File: rtl/updown_wrap16.sv
module updown_wrap16 #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         sclr,
  input  logic         go_up,
  input  logic         go_dn,
  output logic [W-1:0] count,
  output logic         tc_up,
  output logic         tc_dn
);
  localparam logic [W-1:0] TOP = '1;
  localparam logic [W-1:0] ONE = W'(1);

  logic         up_sel, dn_sel;
  logic         core_ld, core_cnt;
  logic [W-1:0] core_din;

  assign up_sel = go_up & ~go_dn;
  assign dn_sel = go_dn & ~go_up;

  // Glue logic: the predecessor is fed to the parallel input, and load replaces increment
  assign core_ld  = dn_sel;
  assign core_cnt = up_sel;
  assign core_din = count - ONE;

  // Up-only core: clear over load over count
  always_ff @(posedge clk) begin
    if (sclr)          count <= '0;
    else if (core_ld)  count <= core_din;
    else if (core_cnt) count <= count + ONE;
  end

  assign tc_up = up_sel & (count == TOP);
  assign tc_dn = dn_sel & (count == '0);
endmodule

module updown_wrap16_chk #(
  parameter int W = 4
) (
  input logic         clk,
  input logic         sclr,
  input logic         go_up,
  input logic         go_dn,
  input logic [W-1:0] count,
  input logic         tc_up,
  input logic         tc_dn
);
  logic armed = 1'b0;
  always_ff @(posedge clk) if (sclr) armed <= 1'b1;

  AST_CLR_ZERO: assert property (@(posedge clk) sclr |=> count == '0); // R1
  AST_UP_STEP:  assert property (@(posedge clk) disable iff (sclr || !armed)
                  (go_up && !go_dn) |=> count == W'($past(count) + W'(1))); // R2
  AST_DN_STEP:  assert property (@(posedge clk) disable iff (sclr || !armed)
                  (!go_up && go_dn) |=> count == W'($past(count) - W'(1))); // R3
  AST_HOLD:     assert property (@(posedge clk) disable iff (sclr || !armed)
                  (go_up == go_dn) |=> $stable(count)); // R4
  AST_TCUP_WRAP: assert property (@(posedge clk) disable iff (sclr || !armed)
                  tc_up |=> count == '0); // R5
  AST_TCDN_WRAP: assert property (@(posedge clk) disable iff (sclr || !armed)
                  tc_dn |=> count == '1); // R6
  AST_TC_EXCL:  assert property (@(posedge clk) disable iff (!armed)
                  $onehot0({tc_up, tc_dn})); // R5 R6
endmodule

bind updown_wrap16 updown_wrap16_chk #(.W(W)) chk_i (
  .clk(clk), .sclr(sclr), .go_up(go_up), .go_dn(go_dn),
  .count(count), .tc_up(tc_up), .tc_dn(tc_dn)
);

// File: tb/updown_wrap16_tb.sv
module updown_wrap16_tb_top;
  logic       clk = 1'b0;
  logic       sclr = 1'b0, go_up = 1'b0, go_dn = 1'b0;
  logic [3:0] count;
  logic       tc_up, tc_dn;
  int         nvec = 0, nbad = 0;
  int         exp_s = 0;

  always #4 clk = ~clk;

  updown_wrap16 dut_i (
    .clk(clk), .sclr(sclr), .go_up(go_up), .go_dn(go_dn),
    .count(count), .tc_up(tc_up), .tc_dn(tc_dn)
  );

  task automatic chk(input string rq, input int act, input int exp);
    nvec++;
    if (act != exp) begin
      nbad++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  task automatic apply(input logic c, input logic u, input logic d, input string rq);
    @(negedge clk);
    sclr = c; go_up = u; go_dn = d;
    #1;
    chk({rq, " R5 tc_up"}, int'(tc_up), int'(u && !d && exp_s == 15));
    chk({rq, " R6 tc_dn"}, int'(tc_dn), int'(d && !u && exp_s == 0));
    @(posedge clk);
    if (c)            exp_s = 0;
    else if (u && !d) exp_s = (exp_s + 1) % 16;
    else if (d && !u) exp_s = (exp_s + 15) % 16;
    #1;
    chk({rq, " count"}, int'(count), exp_s);
  endtask

  initial begin
    #1_000_000;
    nbad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

  initial begin
    int seen;
    // R1 reset state, clear with up mode active
    apply(1'b1, 1'b1, 1'b0, "R1");
    // R2 full up sweep with wrap, R5 flag at 15
    for (int i = 0; i < 20; i++) apply(1'b0, 1'b1, 1'b0, "R2");
    // R4 hold under both equal pairs
    for (int i = 0; i < 3; i++) apply(1'b0, 1'b0, 1'b0, "R4");
    for (int i = 0; i < 3; i++) apply(1'b0, 1'b1, 1'b1, "R4");
    // R1 clear wins over down-mode load
    apply(1'b1, 1'b0, 1'b1, "R1");
    // R7 sixteen down steps from 0, R3 wraps, R6 flag at 0
    seen = 0;
    for (int k = 1; k <= 16; k++) begin
      apply(1'b0, 1'b0, 1'b1, "R3");
      chk("R7 descending", int'(count), (16 - k) % 16);
      seen |= (1 << count);
    end
    chk("R7 all visited", seen, 32'hFFFF);
    chk("R7 back at zero", int'(count), 0);
    // mixed directions
    for (int i = 0; i < 5; i++) apply(1'b0, 1'b1, 1'b0, "R2");
    for (int i = 0; i < 7; i++) apply(1'b0, 1'b0, 1'b1, "R3");
    apply(1'b0, 1'b1, 1'b1, "R4");
    apply(1'b1, 1'b1, 1'b1, "R1");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end
endmodule